// File: doc/BRIEF.md
# Poll-Gated Response Transmit Controller

This block decides when a secondary station on a shared half-duplex HDLC line may send. The station sends only responses, and only after the primary has polled it. Upstream logic delivers the address byte and control byte of each received frame, a frame-end strobe and a CRC verdict. Firmware requests an I-frame with a one-cycle pulse whenever it likes. The block holds that request until a qualifying poll arrives. It then issues a start pulse, marks the outgoing frame as a final response, and after the transmitter reports completion it locks the transmit path until the primary acknowledges the frame.

Frames are matched against the station's own 8-bit address. A second, optional broadcast address can also be enabled. Frames with a bad CRC or a foreign address have no effect. A poll that finds no I-frame queued raises a one-cycle flag, so that firmware can answer with a supervisory response. The block keeps the modulo-8 send sequence number of the I-frame and advances it on each positive acknowledgement.

Top module: `nrm_tx_gate`

## Requirements
- R1: After synchronous reset, tx_start, tx_final, tx_inhibit, pending and poll_nodata are 0, and tx_ns is 0.
- R2: A cpu_req pulse sets pending one cycle later. No tx_start occurs until a qualifying poll is received.
- R3: A good-CRC, address-matching RR frame with P=1 while a request is pending gives a one-cycle tx_start in the cycle after the frame strobe. In that same cycle pending clears and tx_final rises. Control layout: bit0=0 marks an I-frame, bits[1:0]=01 with bits[3:2]=00 marks RR, bit4 is P/F, bits[7:5] is N(R).
- R4: An address-matching I-frame with P=1 grants permission in the same way as an RR frame.
- R5: Frames with P=0, and S-frames other than RR (bits[3:2] not 00), grant no permission.
- R6: A frame with rx_crc_ok=0 or with an address matching neither enabled address neither grants nor acknowledges.
- R7: With bcast_en=1, frames sent to bcast_addr are accepted like frames to own_addr. With bcast_en=0 they are ignored.
- R8: A tx_done pulse while tx_final is high drops tx_final and raises tx_inhibit one cycle later. tx_inhibit stays high across frames whose N(R) is not tx_ns+1 modulo 8.
- R9: While inhibited, an accepted RR or I-frame with N(R)=tx_ns+1 modulo 8 clears tx_inhibit and increments tx_ns modulo 8 (7 wraps to 0).
- R10: An accepted poll with no request pending gives a one-cycle poll_nodata pulse and no tx_start.
- R11: Polls received while the frame is being sent or while inhibited do not start a frame. An acknowledgement that also polls releases the lock and, if a request is pending, starts the next frame in the same cycle that tx_inhibit falls.
- R12: tx_addr presents own_addr, registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 8 | Station secondary address, used for receive and transmit |
| bcast_addr | input | 8 | Optional broadcast receive address |
| bcast_en | input | 1 | Enables matching of bcast_addr |
| rx_valid | input | 1 | One-cycle strobe: a received frame has ended |
| rx_crc_ok | input | 1 | CRC verdict for the strobed frame |
| rx_addr | input | 8 | Address byte of the strobed frame |
| rx_ctrl | input | 8 | Control byte of the strobed frame |
| cpu_req | input | 1 | One-cycle request to send an I-frame |
| tx_done | input | 1 | One-cycle pulse: the transmitter finished the frame |
| tx_start | output | 1 | One-cycle pulse: begin sending the queued I-frame |
| tx_final | output | 1 | High while the granted frame is being sent (F bit = 1) |
| tx_inhibit | output | 1 | Transmit FIFO locked, awaiting acknowledgement |
| pending | output | 1 | An I-frame request is queued |
| poll_nodata | output | 1 | One-cycle flag: polled with nothing queued |
| tx_ns | output | 3 | Send sequence number of the current or next I-frame |
| tx_addr | output | 8 | Address to place in transmitted frames |

## Verification
A wrong state in the permission machine shows at the ports one cycle after the frame strobe that should have moved it. It appears as a missing or spurious tx_start, a tx_inhibit that stays high or drops too early, or a poll_nodata flag where a start belonged. A sequence-number fault stays hidden until the next acknowledgement. At that point an acknowledgement with the correct N(R) fails to release the lock, or tx_ns shows the wrong value. Wrap-around is exercised by cycling the count past 7.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  // Modulo-8 control format: sequence fields are three bits wide.
  localparam int SEQ_W = 3;

  typedef enum logic [1:0] {
    ST_READY    = 2'd0,
    ST_SEND     = 2'd1,
    ST_WAIT_ACK = 2'd2
  } perm_st_t;

  typedef struct packed {
    logic             is_info;
    logic             is_rr;
    logic             pf;
    logic [SEQ_W-1:0] nr;
  } ctrl_info_t;

  function automatic ctrl_info_t decode_ctrl(input logic [7:0] c);
    ctrl_info_t r;
    r.is_info = ~c[0];
    r.is_rr   = (c[1:0] == 2'b01) && (c[3:2] == 2'b00);
    r.pf      = c[4];
    r.nr      = c[7:5];
    return r;
  endfunction
endpackage

// File: rtl/nrm_addr_match.sv
module nrm_addr_match #(
  parameter int ADDR_W    = 8,
  parameter bit HAS_BCAST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_crc_ok,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] bcast_addr,
  input  logic              bcast_en,
  output logic              hit
);
  logic own_hit;
  logic bc_hit;

  assign own_hit = (rx_addr == own_addr);

  generate
    if (HAS_BCAST) begin : g_bcast
      assign bc_hit = bcast_en && (rx_addr == bcast_addr);
    end else begin : g_no_bcast
      logic unused_bc;
      assign unused_bc = bcast_en ^ (^bcast_addr);
      assign bc_hit    = 1'b0;
    end
  endgenerate

  assign hit = rx_valid && rx_crc_ok && (own_hit || bc_hit);

  AST_BAD_CRC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_crc_ok) |-> !hit); // R6
endmodule

// File: rtl/nrm_ctrl_dec.sv
module nrm_ctrl_dec
  import nrm_pkg::*;
(
  input  logic             hit,
  input  logic [7:0]       rx_ctrl,
  input  logic [SEQ_W-1:0] cur_ns,
  output logic             poll,
  output logic             ack
);
  ctrl_info_t       info;
  logic [SEQ_W-1:0] want_nr;
  logic             counts;

  always_comb begin
    info    = decode_ctrl(rx_ctrl);
    want_nr = cur_ns + SEQ_W'(1);
    counts  = hit && (info.is_info || info.is_rr);
    poll    = counts && info.pf;
    ack     = counts && (info.nr == want_nr);
  end
endmodule

// File: rtl/nrm_perm_fsm.sv
module nrm_perm_fsm
  import nrm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             poll,
  input  logic             ack,
  input  logic             cpu_req,
  input  logic             tx_done,
  output logic             tx_start,
  output logic             tx_final,
  output logic             tx_inhibit,
  output logic             pending,
  output logic             poll_nodata,
  output logic [SEQ_W-1:0] ns
);
  perm_st_t st_q, st_n;
  logic     released, ready_now, pend_now, grant, nodata, pend_n;

  always_comb begin
    released  = (st_q == ST_WAIT_ACK) && ack;
    ready_now = (st_q == ST_READY) || released;
    pend_now  = pending || cpu_req;
    grant     = ready_now && poll && pend_now;
    nodata    = ready_now && poll && !pend_now;
    pend_n    = grant ? 1'b0 : pend_now;
    st_n      = st_q;
    unique case (st_q)
      ST_READY:    if (grant) st_n = ST_SEND;
      ST_SEND:     if (tx_done) st_n = ST_WAIT_ACK;
      ST_WAIT_ACK: if (released) st_n = grant ? ST_SEND : ST_READY;
      default:     st_n = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_READY;
      pending     <= 1'b0;
      tx_start    <= 1'b0;
      tx_final    <= 1'b0;
      tx_inhibit  <= 1'b0;
      poll_nodata <= 1'b0;
      ns          <= '0;
    end else begin
      st_q        <= st_n;
      pending     <= pend_n;
      tx_start    <= grant;
      tx_final    <= (st_n == ST_SEND);
      tx_inhibit  <= (st_n == ST_WAIT_ACK);
      poll_nodata <= nodata;
      if (released) ns <= ns + SEQ_W'(1);
    end
  end

  AST_START_AFTER_POLL: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(poll)); // R3
  AST_LOCK_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (tx_final && tx_done) |=> (tx_inhibit && !tx_final)); // R8
  AST_NS_STEPS_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_inhibit) |-> (ns == $past(ns) + SEQ_W'(1))); // R9
  AST_NODATA_NOT_START: assert property (@(posedge clk) disable iff (rst)
    !(tx_start && poll_nodata)); // R10
  AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !tx_inhibit); // R11
  AST_START_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (!pending && tx_final)); // R3
endmodule

// File: rtl/nrm_tx_gate.sv
module nrm_tx_gate
  import nrm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit HAS_BCAST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] bcast_addr,
  input  logic              bcast_en,
  input  logic              rx_valid,
  input  logic              rx_crc_ok,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [7:0]        rx_ctrl,
  input  logic              cpu_req,
  input  logic              tx_done,
  output logic              tx_start,
  output logic              tx_final,
  output logic              tx_inhibit,
  output logic              pending,
  output logic              poll_nodata,
  output logic [SEQ_W-1:0]  tx_ns,
  output logic [ADDR_W-1:0] tx_addr
);
  logic hit, poll, ack;

  nrm_addr_match #(.ADDR_W(ADDR_W), .HAS_BCAST(HAS_BCAST)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok),
    .rx_addr(rx_addr), .own_addr(own_addr), .bcast_addr(bcast_addr),
    .bcast_en(bcast_en), .hit(hit)
  );

  nrm_ctrl_dec u_dec (
    .hit(hit), .rx_ctrl(rx_ctrl), .cur_ns(tx_ns), .poll(poll), .ack(ack)
  );

  nrm_perm_fsm u_fsm (
    .clk(clk), .rst(rst), .poll(poll), .ack(ack), .cpu_req(cpu_req),
    .tx_done(tx_done), .tx_start(tx_start), .tx_final(tx_final),
    .tx_inhibit(tx_inhibit), .pending(pending), .poll_nodata(poll_nodata),
    .ns(tx_ns)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_addr <= '0;
    else     tx_addr <= own_addr;
  end

  AST_ADDR_FOLLOWS_OWN: assert property (@(posedge clk) disable iff (rst)
    $stable(own_addr) && !$rose(rst) |=> (tx_addr == $past(own_addr))); // R12
endmodule

// File: tb/sim_nrm_tx_gate.sv
module sim_nrm_tx_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] OWN = 8'h35;
  localparam logic [7:0] BC  = 8'hFF;

  logic clk = 0, rst = 1;
  logic [7:0] own_addr = OWN, bcast_addr = BC, rx_addr = 0, rx_ctrl = 0;
  logic bcast_en = 0, rx_valid = 0, rx_crc_ok = 0, cpu_req = 0, tx_done = 0;
  logic tx_start, tx_final, tx_inhibit, pending, poll_nodata;
  logic [2:0] tx_ns;
  logic [7:0] tx_addr;
  int n_chk = 0, n_bad = 0;
  logic [2:0] exp_ns = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrm_tx_gate u0 (.*);

  function automatic logic [7:0] rr(input logic [2:0] nr, input logic pf);
    return {nr, pf, 4'b0001};
  endfunction
  function automatic logic [7:0] rnr(input logic [2:0] nr, input logic pf);
    return {nr, pf, 4'b0101};
  endfunction
  function automatic logic [7:0] ifr(input logic [2:0] nr, input logic pf,
                                     input logic [2:0] ns);
    return {nr, pf, ns, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] c, input logic ok);
    @(negedge clk);
    rx_addr = a; rx_ctrl = c; rx_crc_ok = ok; rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic req();
    @(negedge clk); cpu_req = 1;
    @(negedge clk); cpu_req = 0;
  endtask

  task automatic done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 tx_start", tx_start, 0); chk("R1 tx_final", tx_final, 0);
    chk("R1 tx_inhibit", tx_inhibit, 0); chk("R1 pending", pending, 0);
    chk("R1 poll_nodata", poll_nodata, 0); chk("R1 tx_ns", tx_ns, 0);
  endtask

  task automatic t_gate();
    req();
    chk("R2 pending", pending, 1); chk("R2 no start", tx_start, 0);
    frame(OWN, rr(0, 0), 1);      chk("R5 P=0 no start", tx_start, 0);
    frame(OWN, rnr(0, 1), 1);     chk("R5 RNR no start", tx_start, 0);
    frame(OWN, rr(0, 1), 0);      chk("R6 bad crc no start", tx_start, 0);
    frame(8'h36, rr(0, 1), 1);    chk("R6 foreign addr no start", tx_start, 0);
    chk("R2 still pending", pending, 1);
    frame(OWN, rr(0, 1), 1);
    chk("R3 start", tx_start, 1); chk("R3 final", tx_final, 1);
    chk("R3 pending clr", pending, 0); chk("R3 ns", tx_ns, exp_ns);
    chk("R12 tx_addr", tx_addr, OWN);
    @(negedge clk); chk("R3 start one cycle", tx_start, 0);
  endtask

  task automatic t_lock();
    done();
    chk("R8 inhibit", tx_inhibit, 1); chk("R8 final drop", tx_final, 0);
    req();
    frame(OWN, rr(exp_ns, 1), 1);
    chk("R11 no start locked", tx_start, 0); chk("R8 stays locked", tx_inhibit, 1);
    frame(OWN, rr(exp_ns + 3'd1, 1), 0);
    chk("R6 bad crc no ack", tx_inhibit, 1);
    frame(OWN, ifr(exp_ns + 3'd1, 1, 0), 1);
    exp_ns++;
    chk("R9 release", tx_inhibit, 0); chk("R9 ns", tx_ns, exp_ns);
    chk("R11 ack+poll start", tx_start, 1); chk("R4 I-frame poll", tx_final, 1);
    done();
    frame(OWN, rr(exp_ns + 3'd1, 0), 1);
    exp_ns++;
    chk("R9 RR ack", tx_inhibit, 0); chk("R9 ns2", tx_ns, exp_ns);
    chk("R5 ack P=0 no start", tx_start, 0);
  endtask

  task automatic t_nodata();
    frame(OWN, rr(0, 1), 1);
    chk("R10 flag", poll_nodata, 1); chk("R10 no start", tx_start, 0);
    @(negedge clk); chk("R10 pulse", poll_nodata, 0);
  endtask

  task automatic t_bcast();
    bcast_en = 1;
    req();
    frame(BC, ifr(0, 1, 0), 1);
    chk("R7 bcast start", tx_start, 1);
    done();
    frame(BC, rr(exp_ns + 3'd1, 0), 1);
    exp_ns++;
    chk("R7 bcast ack", tx_inhibit, 0); chk("R7 ns", tx_ns, exp_ns);
    bcast_en = 0;
    req();
    frame(BC, rr(0, 1), 1);
    chk("R7 disabled no start", tx_start, 0); chk("R7 pending kept", pending, 1);
    frame(OWN, rr(0, 1), 1);
    chk("R3 own start", tx_start, 1);
    done();
    frame(OWN, rr(exp_ns + 3'd1, 0), 1);
    exp_ns++;
    chk("R9 ns3", tx_ns, exp_ns);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) begin
      req();
      frame(OWN, rr(0, 1), 1);
      done();
      frame(OWN, rr(exp_ns + 3'd1, 0), 1);
      exp_ns++;
    end
    chk("R9 wrap ns", tx_ns, 0); chk("R9 wrap unlocked", tx_inhibit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_lock();
    t_nodata();
    t_bcast();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule